// File: doc/BRIEF.md
# PCM Voice Serial Port

This block is the digital framing port of a telephone voice codec. Once per 8 kHz frame it sends one voice sample out on a serial data line and takes one sample in. The frame sync pulse marks where each frame begins. The bit clock may run at any rate the sample format allows. The transmit sample arrives on a parallel input. The received sample leaves on a parallel output, together with a one-cycle valid strobe.

A mode input picks the sample format:
- A-law or µ-law, which use 8-bit companded words;
- 14-bit linear, which uses a 16-bit slot.

The block does no companding arithmetic.

Every input is oversampled by a fast free-running reference clock:
- Serial data is captured on falling bit-clock edges.
- Serial data is launched on rising bit-clock edges.

When the line carries no word, the serial output is parked high. If either the bit clock or the frame sync stops toggling for a programmable number of reference cycles, the block reports a partial power-down. That report stays up until a valid frame start is seen.

Top module: `pcm_voice_port`

## Requirements
- R1: After reset, `sdout_o` is 1, `rx_valid_o` is 0, `stall_o` is 0 and `rx_word_o` is 0.
- R2: A frame starts at a rising bit-clock edge where `fsync_i` is high and was low at the previous rising edge. Its first bit is the most significant bit of the word.
- R3: Each transmit bit is driven after a rising bit-clock edge and is held until the next rising edge.
- R4: Receive bits are sampled on falling bit-clock edges, most significant bit first. After the last bit of the slot, `rx_valid_o` pulses high for exactly one reference cycle, with the word on `rx_word_o`.
- R5: In companded modes (`mode_i` = 2'b00 A-law, 2'b01 µ-law) the slot is 8 bits. Only `tx_word_i[7:0]` is sent. The received byte appears in `rx_word_o[7:0]`, and the upper bits are 0.
- R6: In linear mode (`mode_i[1]` = 1) the slot is 16 bits: `tx_word_i[13:0]` followed by two 0 bits. `rx_word_o[13:0]` holds the first 14 received bits, and the two trailing received bits are ignored.
- R7: Outside the active slot, `sdout_o` is 1.
- R8: While `pdn_i` is high, `sdout_o` is 1 from the next reference cycle on. A frame in progress is dropped, and it produces no `rx_valid_o` pulse.
- R9: If the bit clock or the frame sync shows no edge for `STALL_CYC` reference cycles, `stall_o` goes high. The frame in progress is dropped, and `sdout_o` is held at 1.
- R10: `stall_o` clears at the next frame start, and that frame is transferred normally.
- R11: The mode and the transmit word are captured at frame start. Changing either during the slot does not change the word that is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, oversampled |
| fsync_i | input | 1 | Frame sync, oversampled |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data, parked high when idle |
| mode_i | input | 2 | Sample format: 00 A-law, 01 µ-law, 1x linear |
| pdn_i | input | 1 | Power-down request |
| tx_word_i | input | LIN_W | Transmit sample, captured at frame start |
| rx_word_o | output | LIN_W | Last received sample |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_word_o` is updated |
| stall_o | output | 1 | Stuck bit clock or sync detected |

## Verification
The assertions assume that the bit clock and frame sync are slow compared with the reference clock, with each level held for more than `SYNC_STAGES` cycles. This keeps every edge visible after synchronisation and ensures that a rising-edge event and a falling-edge event never fall in the same cycle. They also assume that `fsync_i` changes together with the rising bit-clock edge and that `sdin_i` is steady across the falling edge. The bench keeps to these assumptions:
- It holds each bit-clock phase for four reference cycles.
- It changes sync and data only at the rising bit-clock edge.
- It keeps normal frames shorter than the stall timeout.

The stall checks compare `stall_o` against quiet-time counters that the checker keeps on the raw inputs.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

   typedef enum logic [1:0] {
      FMT_ALAW  = 2'b00,
      FMT_ULAW  = 2'b01,
      FMT_LIN   = 2'b10,
      FMT_LIN_B = 2'b11
   } pcm_fmt_e;

   function automatic logic fmt_is_linear(input logic [1:0] mode);
      return mode[1];
   endfunction

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic chg
);
   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], d};
   end

   assign lvl = pipe[STAGES-1];
   assign chg = pipe[STAGES-1] ^ pipe[STAGES];
endmodule

// File: rtl/pcm_quiet_mon.sv
module pcm_quiet_mon #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic activity,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (activity)      cnt <= '0;
      else if (cnt != LIM)    cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == LIM);
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
   parameter int CMP_W = 8,
   parameter int LIN_W = 14,
   parameter int PAD_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             start,
   input  logic             abort,
   input  logic             linear,
   input  logic [LIN_W-1:0] word,
   output logic             sdout
);
   localparam int SLOT_MAX = LIN_W + PAD_W;
   localparam int CNT_W    = $clog2(SLOT_MAX + 1);
   localparam logic [CNT_W-1:0] LEN_LIN = CNT_W'(SLOT_MAX);
   localparam logic [CNT_W-1:0] LEN_CMP = CNT_W'(CMP_W);

   logic [SLOT_MAX-1:0] load, sr;
   logic [CNT_W-1:0]    cnt, len;
   logic                active;

   assign load = linear ? {word, {PAD_W{1'b0}}}
                        : {word[CMP_W-1:0], {(SLOT_MAX-CMP_W){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdout  <= 1'b1;
         active <= 1'b0;
         sr     <= '0;
         cnt    <= '0;
         len    <= LEN_CMP;
      end else if (abort) begin
         sdout  <= 1'b1;
         active <= 1'b0;
      end else if (start) begin
         sdout  <= load[SLOT_MAX-1];
         sr     <= {load[SLOT_MAX-2:0], 1'b0};
         cnt    <= CNT_W'(1);
         len    <= linear ? LEN_LIN : LEN_CMP;
         active <= 1'b1;
      end else if (launch && active) begin
         if (cnt == len) begin
            sdout  <= 1'b1;
            active <= 1'b0;
         end else begin
            sdout <= sr[SLOT_MAX-1];
            sr    <= {sr[SLOT_MAX-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
   parameter int CMP_W = 8,
   parameter int LIN_W = 14,
   parameter int PAD_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample,
   input  logic             start,
   input  logic             abort,
   input  logic             linear,
   input  logic             sdin,
   output logic [LIN_W-1:0] word,
   output logic             valid
);
   localparam int SLOT_MAX = LIN_W + PAD_W;
   localparam int CNT_W    = $clog2(SLOT_MAX + 1);
   localparam logic [CNT_W-1:0] LAST_LIN = CNT_W'(SLOT_MAX - 1);
   localparam logic [CNT_W-1:0] LAST_CMP = CNT_W'(CMP_W - 1);

   logic [SLOT_MAX-1:0] sr, nxt;
   logic [CNT_W-1:0]    cnt, last;
   logic                active, lin_q;

   assign nxt = {sr[SLOT_MAX-2:0], sdin};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr     <= '0;
         cnt    <= '0;
         last   <= LAST_CMP;
         active <= 1'b0;
         lin_q  <= 1'b0;
         word   <= '0;
         valid  <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (abort) begin
            active <= 1'b0;
         end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            lin_q  <= linear;
            last   <= linear ? LAST_LIN : LAST_CMP;
         end else if (sample && active) begin
            sr  <= nxt;
            cnt <= cnt + 1'b1;
            if (cnt == last) begin
               active <= 1'b0;
               valid  <= 1'b1;
               word   <= lin_q ? nxt[SLOT_MAX-1:PAD_W] : LIN_W'(nxt[CMP_W-1:0]);
            end
         end
      end
   end
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
   import pcm_port_pkg::*;
#(
   parameter int CMP_W       = 8,
   parameter int LIN_W       = 14,
   parameter int PAD_W       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int STALL_CYC   = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_i,
   input  logic             fsync_i,
   input  logic             sdin_i,
   output logic             sdout_o,
   input  logic [1:0]       mode_i,
   input  logic             pdn_i,
   input  logic [LIN_W-1:0] tx_word_i,
   output logic [LIN_W-1:0] rx_word_o,
   output logic             rx_valid_o,
   output logic             stall_o
);
   localparam int N_MON = 2;

   initial begin
      assert (CMP_W >= 2 && CMP_W < LIN_W + PAD_W)
         else $error("pcm_voice_port: CMP_W out of range");
      assert (PAD_W >= 1) else $error("pcm_voice_port: PAD_W must be >= 1");
      assert (SYNC_STAGES >= 2) else $error("pcm_voice_port: SYNC_STAGES must be >= 2");
      assert (STALL_CYC >= 4) else $error("pcm_voice_port: STALL_CYC too small");
   end

   logic bclk_lvl, bclk_chg, sync_lvl, sync_chg;
   logic bclk_rise, bclk_fall, frame_start, sync_at_rise;
   logic abort_tx_rx;
   logic [SYNC_STAGES-1:0] sdin_pipe;
   logic [N_MON-1:0] mon_act, mon_exp;

   pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
      .clk(clk), .rst_n(rst_n), .d(bclk_i), .lvl(bclk_lvl), .chg(bclk_chg));

   pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_fsync_sync (
      .clk(clk), .rst_n(rst_n), .d(fsync_i), .lvl(sync_lvl), .chg(sync_chg));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sdin_pipe <= '0;
      else        sdin_pipe <= {sdin_pipe[SYNC_STAGES-2:0], sdin_i};
   end

   assign bclk_rise   = bclk_chg & bclk_lvl;
   assign bclk_fall   = bclk_chg & ~bclk_lvl;
   assign frame_start = bclk_rise & sync_lvl & ~sync_at_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sync_at_rise <= 1'b0;
      else if (bclk_rise) sync_at_rise <= sync_lvl;
   end

   assign mon_act = {sync_chg, bclk_chg};

   for (genvar g = 0; g < N_MON; g++) begin : g_mon
      pcm_quiet_mon #(.LIMIT(STALL_CYC)) u_mon (
         .clk(clk), .rst_n(rst_n), .activity(mon_act[g]), .expired(mon_exp[g]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stall_o <= 1'b0;
      else if (frame_start) stall_o <= 1'b0;
      else if (|mon_exp)    stall_o <= 1'b1;
   end

   assign abort_tx_rx = pdn_i | (stall_o & ~frame_start);

   pcm_tx_shift #(.CMP_W(CMP_W), .LIN_W(LIN_W), .PAD_W(PAD_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .launch(bclk_rise), .start(frame_start),
      .abort(abort_tx_rx), .linear(fmt_is_linear(mode_i)), .word(tx_word_i),
      .sdout(sdout_o));

   pcm_rx_shift #(.CMP_W(CMP_W), .LIN_W(LIN_W), .PAD_W(PAD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .sample(bclk_fall), .start(frame_start),
      .abort(abort_tx_rx), .linear(fmt_is_linear(mode_i)),
      .sdin(sdin_pipe[SYNC_STAGES-1]), .word(rx_word_o), .valid(rx_valid_o));
endmodule

// File: rtl/pcm_voice_port_sva.sv
module pcm_voice_port_sva #(
   parameter int STALL_CYC = 4096
) (
   input logic clk,
   input logic rst_n,
   input logic bclk_i,
   input logic fsync_i,
   input logic pdn_i,
   input logic sdout_o,
   input logic rx_valid_o,
   input logic stall_o
);
   localparam int QMAX = 2 * STALL_CYC;
   localparam int QW   = $clog2(QMAX + 1);

   logic [QW-1:0] bq, sq;
   logic          bclk_prev, sync_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bq <= '0; sq <= '0; bclk_prev <= 1'b0; sync_prev <= 1'b0;
      end else begin
         bclk_prev <= bclk_i;
         sync_prev <= fsync_i;
         if (bclk_i != bclk_prev) bq <= '0;
         else if (bq != QW'(QMAX)) bq <= bq + 1'b1;
         if (fsync_i != sync_prev) sq <= '0;
         else if (sq != QW'(QMAX)) sq <= sq + 1'b1;
      end
   end

   p_pdn_parks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pdn_i |=> sdout_o);

   p_pdn_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pdn_i |=> !rx_valid_o);

   p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   p_stall_parks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && $past(stall_o)) |-> sdout_o);

   p_stall_after_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_o) |-> (bq >= QW'(STALL_CYC) || sq >= QW'(STALL_CYC)));
endmodule

bind pcm_voice_port pcm_voice_port_sva #(.STALL_CYC(STALL_CYC)) u_sva (
   .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fsync_i(fsync_i), .pdn_i(pdn_i),
   .sdout_o(sdout_o), .rx_valid_o(rx_valid_o), .stall_o(stall_o));

// File: tb/pcm_voice_port_tb_top.sv
`timescale 1ns/1ps
module pcm_voice_port_tb_top;
   localparam int LIN_W = 14;
   localparam int STALL = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0, fsync = 1'b0, sdin = 1'b0, pdn = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [LIN_W-1:0] tx_word = '0;
   logic sdout, rx_valid, stall;
   logic [LIN_W-1:0] rx_word;

   int checks = 0, errors = 0, vcount = 0;
   bit done = 0;
   logic [15:0] cap;
   bit idle_ok;

   always #2.5 clk = ~clk;

   pcm_voice_port #(.STALL_CYC(STALL)) dut_i (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdin_i(sdin),
      .sdout_o(sdout), .mode_i(mode), .pdn_i(pdn), .tx_word_i(tx_word),
      .rx_word_o(rx_word), .rx_valid_o(rx_valid), .stall_o(stall));

   always @(negedge clk) if (rx_valid) vcount++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one frame: slot bits then idle bits; bclk period 8 reference cycles
   task automatic frame(input logic [1:0] md, input logic [LIN_W-1:0] tw,
                        input logic [15:0] rxb, input int pdn_bit,
                        input logic [LIN_W-1:0] tw_late);
      int slot;
      slot = md[1] ? 16 : 8;
      mode = md; tx_word = tw; cap = '1; idle_ok = 1;
      for (int k = 0; k < slot + 4; k++) begin
         @(negedge clk);
         bclk = 1'b1;
         fsync = (k == 0);
         sdin = (k < slot) ? rxb[15-k] : 1'b0;
         if (pdn_bit >= 0 && k >= pdn_bit) pdn = 1'b1;
         if (k == 2) begin tx_word = tw_late; mode = ~md; end
         repeat (3) @(negedge clk);
         if (k < slot) cap[15-k] = sdout;
         else if (sdout !== 1'b1) idle_ok = 0;
         @(negedge clk);
         bclk = 1'b0;
         repeat (3) @(negedge clk);
      end
      pdn = 1'b0;
      mode = md;
   endtask

   task automatic free_bits(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); bclk = 1'b1; fsync = 1'b0;
         repeat (4) @(negedge clk); bclk = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk("R1 sdout", sdout, 1);
      chk("R1 rx_valid", rx_valid, 0);
      chk("R1 stall", stall, 0);
      chk("R1 rx_word", rx_word, 0);
   endtask

   task automatic t_alaw;
      int v0 = vcount;
      frame(2'b00, 14'h00A5, 16'h3C00, -1, 14'h00A5);
      chk("R2 R3 R5 alaw tx", cap[15:8], 8'hA5);
      chk("R4 R5 alaw rx", rx_word, 14'h003C);
      chk("R4 alaw valid count", vcount - v0, 1);
      chk("R7 alaw idle high", idle_ok, 1);
   endtask

   task automatic t_ulaw;
      int v0 = vcount;
      frame(2'b01, 14'h3F81, 16'hE7FF, -1, 14'h3F81);
      chk("R5 ulaw tx", cap[15:8], 8'h81);
      chk("R5 ulaw rx upper zero", rx_word, 14'h00E7);
      chk("R4 ulaw valid count", vcount - v0, 1);
      chk("R7 ulaw idle high", idle_ok, 1);
   endtask

   task automatic t_linear;
      int v0 = vcount;
      frame(2'b10, 14'h2D4B, {14'h1234, 2'b11}, -1, 14'h2D4B);
      chk("R6 linear tx", cap, {14'h2D4B, 2'b00});
      chk("R6 linear rx", rx_word, 14'h1234);
      chk("R4 linear valid count", vcount - v0, 1);
      chk("R7 linear idle high", idle_ok, 1);
   endtask

   task automatic t_late_change;
      frame(2'b10, 14'h0F0F, {14'h2AAA, 2'b00}, -1, 14'h3333);
      chk("R11 tx word captured", cap, {14'h0F0F, 2'b00});
      chk("R11 mode captured rx", rx_word, 14'h2AAA);
   endtask

   task automatic t_pdn;
      int v0 = vcount;
      frame(2'b10, 14'h0000, 16'h5555, 5, 14'h0000);
      chk("R8 pdn parks output", cap[10:0], 11'h7FF);
      chk("R8 pdn drops rx word", vcount - v0, 0);
      v0 = vcount;
      frame(2'b00, 14'h0042, 16'h9900, -1, 14'h0042);
      chk("R8 recovery tx", cap[15:8], 8'h42);
      chk("R8 recovery valid", vcount - v0, 1);
   endtask

   task automatic t_stall_clk;
      repeat (STALL + 40) @(negedge clk);
      chk("R9 bclk stall flag", stall, 1);
      chk("R9 bclk stall parks", sdout, 1);
      frame(2'b00, 14'h00C3, 16'h1800, -1, 14'h00C3);
      chk("R10 stall cleared", stall, 0);
      chk("R10 frame after stall tx", cap[15:8], 8'hC3);
      chk("R10 frame after stall rx", rx_word, 14'h0018);
   endtask

   task automatic t_stall_sync;
      free_bits(40);
      chk("R9 sync stall flag", stall, 1);
      chk("R9 sync stall parks", sdout, 1);
      frame(2'b10, 14'h1ABC, {14'h0DEF, 2'b10}, -1, 14'h1ABC);
      chk("R10 sync stall cleared", stall, 0);
      chk("R10 linear after stall", cap, {14'h1ABC, 2'b00});
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_alaw();
      t_ulaw();
      t_linear();
      t_late_change();
      t_pdn();
      t_stall_clk();
      t_stall_sync();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule